// File: doc/BRIEF.md
# Strobe-Assisted SPI Byte Transmitter

This block is a transmit-only SPI engine that hangs off a slow 8-bit processor bus. It feeds two displays that share one serial clock line and one data line, and each display has its own active-low select. Software writes a byte into a holding register. It sets the selects through a control register, then touches a fire address. That bus access itself produces the first serial clock pulse. After the pulse ends, a burst generator in a fast clock domain produces the other seven pulses by itself. The processor can carry on with other work during the burst.

The data line always carries the most significant bit first. The pulse generator runs at the fast clock divided by two, so with a 14 MHz fast clock the automatic pulses run at 7 MHz with a 50% duty cycle. A busy bit in the control register stays set from the fire access until the burst is over. The block ignores fire accesses and data writes that arrive while busy is set. Enabling both selects sends one byte to both displays in the same transfer, which halves the time for drawing shared content.

Top module: `cpu_spi_burst`

## Requirements
- R1: After reset both `spi_cs_n` bits are 1, `spi_sck` is 0, and a read of the control register (address 2) returns 0.
- R2: When the block is idle, any access (read or write) to the fire address (address 1) drives `spi_sck` high for exactly one bus clock period, starting at the bus edge that samples the access. This is the first of the byte's pulses.
- R3: Each accepted fire yields exactly 8 rising edges on `spi_sck` in total. The hardware adds exactly 7 after the first pulse, and `spi_sck` then stays low.
- R4: Each automatic pulse is high for one fast clock period, and consecutive automatic rising edges are two fast clock periods apart.
- R5: A slave that samples `spi_mosi` on rising `spi_sck` receives the last byte accepted at address 0, most significant bit first. The data line advances on falling `spi_sck`.
- R6: Bit 7 of the control register reads 1 from the cycle after an accepted fire. It clears only after the seventh automatic pulse has fallen.
- R7: While busy is 1, an access to address 1 adds no pulses and a write to address 0 changes neither the byte held at address 0 nor the byte that is sent.
- R8: A write to address 2 sets the selects: wdata bit 0 = 1 drives `spi_cs_n[0]` low, and bit 1 = 1 drives `spi_cs_n[1]` low. Both may be low together. Bits 1:0 of the control register read back the enabled selects.
- R9: A read of address 0 returns the byte last accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor bus clock |
| fast_clk | input | 1 | Pulse generator clock, twice the automatic SCK rate |
| rst | input | 1 | Synchronous active-high reset, held for several bus cycles |
| bus_sel | input | 1 | Bus access to this block in the current bus cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 fire, 2 control |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid after the bus edge that samples the read |
| spi_sck | output | 1 | Serial clock shared by both displays |
| spi_mosi | output | 1 | Serial data shared by both displays |
| spi_cs_n | output | NUM_CS | Active-low selects, one per display |

## Verification
The bench sends every one of the 256 byte values, cycling through the four select patterns, including none and both. A slave model measures each transfer: it counts rising edges, times each pulse and each gap, and records the select lines. A design that was off by one in the burst counter would show 7 or 9 edges. A design that shifted on the wrong edge would deliver a byte rotated by one bit. The bench also fires and rewrites the data register while busy is set: a design without the busy guard would send 16 pulses or a corrupted byte. It also checks that busy does not clear before all eight edges have been seen, because a flag that cleared early would let software start the next byte in the middle of a burst.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DATA  = 2'd0,
    REG_FIRE  = 2'd1,
    REG_CTRL  = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/burst_tog_sync.sv
module burst_tog_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic edge_out
);
  // chain[STAGES-1:0] are synchroniser flops, chain[STAGES] holds the prior value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tog_in};
  end

  assign edge_out = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/burst_bus_regs.sv
module burst_bus_regs
  import spi_burst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  done_pulse,
  output logic [DATA_W-1:0]     rdata,
  output logic [DATA_W-1:0]     tx_hold,
  output logic                  load_tog,
  output logic                  fire_tog,
  output logic                  sck_cpu,
  output logic [NUM_CS-1:0]     cs_n
);
  logic busy;
  logic fire_hit, data_wr, ctrl_wr;
  logic [DATA_W-1:0] status;

  assign fire_hit = sel && (addr == REG_FIRE) && !busy;
  assign data_wr  = sel && we && (addr == REG_DATA) && !busy;
  assign ctrl_wr  = sel && we && (addr == REG_CTRL);

  always_comb begin
    status               = '0;
    status[NUM_CS-1:0]   = ~cs_n;
    status[DATA_W-1]     = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sck_cpu  <= 1'b0;
      fire_tog <= 1'b0;
      load_tog <= 1'b0;
      tx_hold  <= '0;
      cs_n     <= '1;
      rdata    <= '0;
    end else begin
      // first pulse lasts one bus cycle; the burst request leaves as it falls
      sck_cpu <= fire_hit;
      if (sck_cpu) fire_tog <= ~fire_tog;
      if (data_wr) begin
        tx_hold  <= wdata;
        load_tog <= ~load_tog;
      end
      if (ctrl_wr) cs_n <= ~wdata[NUM_CS-1:0];
      if (fire_hit)        busy <= 1'b1;
      else if (done_pulse) busy <= 1'b0;
      rdata <= '0;
      if (sel && !we) begin
        case (addr)
          REG_DATA: rdata <= tx_hold;
          REG_CTRL: rdata <= status;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  AST_CPU_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sck_cpu |=> !sck_cpu); // R2
  AST_BUSY_DURING_FIRST: assert property (@(posedge clk) disable iff (rst)
    sck_cpu |-> busy); // R6
  AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && sel && we && addr == REG_DATA) |=> $stable(tx_hold)); // R7
endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_pulse,
  input  logic              fire_pulse,
  input  logic [DATA_W-1:0] tx_hold,
  output logic              sck_auto,
  output logic              mosi,
  output logic              done_tog
);
  localparam int unsigned AUTO_PULSES = DATA_W - 1;
  localparam int unsigned CNT_W       = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      left     <= '0;
      active   <= 1'b0;
      sck_auto <= 1'b0;
      done_tog <= 1'b0;
    end else if (load_pulse && !active) begin
      shreg <= tx_hold;
    end else if (fire_pulse && !active) begin
      // the bus-driven first pulse has already fallen: advance once
      shreg    <= shreg << 1;
      active   <= 1'b1;
      left     <= CNT_W'(AUTO_PULSES);
      sck_auto <= 1'b0;
    end else if (active) begin
      if (!sck_auto) begin
        sck_auto <= 1'b1;
      end else begin
        sck_auto <= 1'b0;
        shreg    <= shreg << 1;
        left     <= left - CNT_W'(1);
        if (left == CNT_W'(1)) begin
          active   <= 1'b0;
          done_tog <= ~done_tog;
        end
      end
    end
  end

  assign mosi = shreg[DATA_W-1];

  AST_AUTO_HALF_RATE: assert property (@(posedge clk) disable iff (rst)
    sck_auto |=> !sck_auto); // R4
  AST_AUTO_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    sck_auto |-> active); // R3
  AST_BURST_ENDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (!sck_auto && $past(sck_auto))); // R3
endmodule

// File: rtl/cpu_spi_burst.sv
module cpu_spi_burst
  import spi_burst_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_CS      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  bus_clk,
  input  logic                  fast_clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  spi_sck,
  output logic                  spi_mosi,
  output logic [NUM_CS-1:0]     spi_cs_n
);
  logic [DATA_W-1:0] tx_hold;
  logic load_tog, fire_tog, done_tog;
  logic load_pulse, fire_pulse, done_pulse;
  logic sck_cpu, sck_auto;

  burst_bus_regs #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_regs (
    .clk(bus_clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .done_pulse(done_pulse), .rdata(bus_rdata),
    .tx_hold(tx_hold), .load_tog(load_tog), .fire_tog(fire_tog),
    .sck_cpu(sck_cpu), .cs_n(spi_cs_n)
  );

  burst_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_load (
    .clk(fast_clk), .rst(rst), .tog_in(load_tog), .edge_out(load_pulse)
  );

  burst_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_fire (
    .clk(fast_clk), .rst(rst), .tog_in(fire_tog), .edge_out(fire_pulse)
  );

  burst_tog_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk(bus_clk), .rst(rst), .tog_in(done_tog), .edge_out(done_pulse)
  );

  burst_pulse_gen #(.DATA_W(DATA_W)) u_gen (
    .clk(fast_clk), .rst(rst), .load_pulse(load_pulse), .fire_pulse(fire_pulse),
    .tx_hold(tx_hold), .sck_auto(sck_auto), .mosi(spi_mosi), .done_tog(done_tog)
  );

  // both sources are flops and never high together: the burst starts after sck_cpu falls
  assign spi_sck = sck_cpu | sck_auto;
endmodule

// File: tb/cpu_spi_burst_test.sv
module cpu_spi_burst_test;
  localparam int BUS_PERIOD  = 80;
  localparam int FAST_PERIOD = 10;
  localparam int DW          = 8;

  logic bus_clk = 1'b0, fast_clk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic spi_sck, spi_mosi;
  logic [1:0] spi_cs_n;

  int total = 0, bad = 0;

  cpu_spi_burst uut (
    .bus_clk(bus_clk), .fast_clk(fast_clk), .rst(rst), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n)
  );

  initial forever #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  initial forever #(FAST_PERIOD/2) fast_clk = ~fast_clk;

  // slave model: samples on rising SCK and times every pulse
  int pcnt = 0;
  logic [DW-1:0] rx = '0;
  logic [1:0] cs_first = '1;
  bit cs_bad = 0, auto_bad = 0;
  longint last_rise = 0, first_w = 0;

  always @(posedge spi_sck) begin
    rx = {rx[DW-2:0], spi_mosi};
    if (pcnt == 0) cs_first = spi_cs_n;
    else if (spi_cs_n != cs_first) cs_bad = 1;
    if (pcnt >= 2 && ($time - last_rise) != 2*FAST_PERIOD) auto_bad = 1;
    last_rise = $time;
    pcnt = pcnt + 1;
  end

  always @(negedge spi_sck) begin
    if (pcnt == 1) first_w = $time - last_rise;
    else if (($time - last_rise) != FAST_PERIOD) auto_bad = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_slave();
    pcnt = 0; rx = '0; cs_bad = 0; auto_bad = 0; first_w = 0;
  endtask

  // called at a bus negedge; returns at the next one
  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge bus_clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output bit cleared);
    logic [DW-1:0] r;
    cleared = 0;
    for (int i = 0; i < 40; i++) begin
      bus_rd(2'd2, r);
      if (!r[DW-1]) begin cleared = 1; break; end
    end
  endtask

  task automatic transfer(input logic [1:0] cs, input logic [DW-1:0] b);
    logic [DW-1:0] r;
    bit cleared;
    bus_wr(2'd2, {6'd0, cs});
    bus_wr(2'd0, b);
    clear_slave();
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd2, r);
    chk(r[DW-1] == 1'b1, "R6", "busy after fire", r[DW-1], 1);
    wait_idle(cleared);
    chk(cleared, "R6", "busy cleared", cleared, 1);
    chk(pcnt == 8, "R6", "edges seen when busy cleared", pcnt, 8);
    repeat (4) @(negedge bus_clk);
    chk(pcnt == 8, "R3", "edges per fire", pcnt, 8);
    chk(rx == b, "R5", "received byte", rx, b);
    chk(cs_first == ~cs && !cs_bad, "R8", "selects during transfer", cs_first, ~cs);
    chk(first_w == BUS_PERIOD, "R2", "first pulse width", first_w, BUS_PERIOD);
    chk(!auto_bad, "R4", "automatic pulse timing", auto_bad, 0);
  endtask

  initial begin
    #(BUS_PERIOD * 20000);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    bit cleared;
    repeat (4) @(negedge bus_clk);
    rst = 0;
    @(negedge bus_clk);

    // R1 reset state
    chk(spi_cs_n == 2'b11, "R1", "cs_n after reset", spi_cs_n, 3);
    chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
    bus_rd(2'd2, r);
    chk(r == 8'h00, "R1", "control after reset", r, 0);

    // R9 data readback
    bus_wr(2'd0, 8'h5A);
    bus_rd(2'd0, r);
    chk(r == 8'h5A, "R9", "data readback", r, 8'h5A);

    // R8 both selects together
    bus_wr(2'd2, 8'h03);
    bus_rd(2'd2, r);
    chk(r == 8'h03, "R8", "control readback", r, 3);
    chk(spi_cs_n == 2'b00, "R8", "both selects low", spi_cs_n, 0);
    bus_wr(2'd2, 8'h02);
    chk(spi_cs_n == 2'b01, "R8", "only select 1 low", spi_cs_n, 1);

    // R2 R3 R4 R5 R6 R8 sweep of all byte values over all select patterns
    for (int v = 0; v < 256; v++) transfer(2'(v), 8'(v));

    // R7 fire and data write while busy are ignored
    bus_wr(2'd2, 8'h01);
    bus_wr(2'd0, 8'hA5);
    clear_slave();
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h3C);
    bus_wr(2'd1, 8'h00);
    wait_idle(cleared);
    repeat (6) @(negedge bus_clk);
    chk(pcnt == 8, "R7", "edges with fire while busy", pcnt, 8);
    chk(rx == 8'hA5, "R7", "byte with write while busy", rx, 8'hA5);
    bus_rd(2'd0, r);
    chk(r == 8'hA5, "R7", "held byte after busy write", r, 8'hA5);

    // R2 a read of the fire address also starts a byte
    bus_wr(2'd0, 8'hC3);
    clear_slave();
    bus_rd(2'd1, r);
    wait_idle(cleared);
    repeat (4) @(negedge bus_clk);
    chk(pcnt == 8, "R2", "edges after fire read", pcnt, 8);
    chk(rx == 8'hC3, "R2", "byte after fire read", rx, 8'hC3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule